// File: doc/BRIEF.md
# Interrupt-Code Acknowledge Tracker

This block keeps per-interrupt status for a serial link that carries interrupt-codes and their acknowledge-codes. It takes decoded receive events and software-initiated transmit events. A receive event carries a code type and an interrupt number. A transmit event carries an interrupt number and a timeout reload value. It records three kinds of sticky status:
- an interrupt-code was received;
- an acknowledge was received for a code that software had sent;
- a code that software sent got no acknowledge in time.

Every status update is gated by a per-interrupt tick-out mask.

Each interrupt has its own pending flag and down-counter. A transmit event arms the flag and loads the counter. A matching acknowledge disarms the flag. If the counter runs out first, the timeout status is set. Software reads the status through a small register port and clears bits by writing ones. An extended mode covers interrupt numbers 32 to 63 in two ways: it reuses the acknowledge word as the upper half of the received-interrupt status, and it opens a second timeout word.

Top module: `icat_track`

## Requirements
- R1: While reset is asserted, and after reset, every readable status word is zero.
- R2: A received interrupt-code (`rx_is_ack`=0) for number n sets received-status bit n only if `tick_mask[n]` is 1. Numbers 0..31 appear in word 0 at bit n.
- R3: Outside extended mode, a received acknowledge-code (`rx_is_ack`=1) for n<32 sets bit n of word 1. It does so only if n is pending and `tick_mask[n]` is 1.
- R4: An acknowledge for a number that is not pending is dropped. It sets no status and disarms nothing, so an acknowledge that arrives after a timeout records nothing.
- R5: A send with reload value R arms the number. If no acknowledge arrives, the timeout bit appears R+1 cycles after the send edge, and only if the mask bit is 1. Numbers 0..31 are in word 2. When an acknowledge arrives on the same edge as the expiry, the acknowledge wins.
- R6: These events are ignored, and their bits read as zero:
  - numbers at or above `NUM_INT`;
  - numbers 32 and above outside extended mode.

  Read addresses 4 to 7 return zero.
- R7: In extended mode, word 1 shows received-interrupt status for 32..63 at bit n-32. Word 3 shows timeouts for 32..63 at bit n-32. Outside extended mode, word 3 reads zero.
- R8: Writing a word clears each status bit whose data bit is 1 and leaves the other bits alone. A hardware set on the same edge as a clear keeps the bit at 1.
- R9: A new send for a number that is already pending reloads its counter and restarts the timeout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Extended mode for numbers 32..63 |
| rx_valid | input | 1 | A decoded code was received this cycle |
| rx_is_ack | input | 1 | 0 = interrupt-code, 1 = acknowledge-code |
| rx_num | input | 6 | Interrupt number of the received code |
| tx_valid | input | 1 | Software sent an interrupt-code this cycle |
| tx_num | input | 6 | Interrupt number of the sent code |
| tx_reload | input | CNT_W | Timeout reload value for the sent code |
| tick_mask | input | 64 | Per-interrupt status enable |
| wr_en | input | 1 | Write-to-clear strobe |
| wr_addr | input | 3 | Word written (0..3) |
| wr_data | input | 32 | Ones select bits to clear |
| rd_addr | input | 3 | Word read |
| rd_data | output | 32 | Read data, combinational |

## Verification
Directed patterns each separate one candidate fault:
- An acknowledge after a send is paired with an acknowledge that has no send and with an acknowledge that arrives after the timeout. This tells pending-gated recording apart from blind recording.
- A send left to expire is probed one cycle early and on the exact cycle. This pins the counter length.
- An acknowledge on the very edge of expiry separates the ack-wins rule from timeout-wins.
- A re-send part-way through the window shows whether the counter is reloaded.
- Masked numbers, numbers above the configured count and high numbers outside extended mode show that each gate is present.
- A clear on the same edge as a set exposes which of the two wins.

A long random phase varies the mask and the mode. It compares all eight read words against the bench model on every clock.

// File: rtl/icat_pkg.sv
`timescale 1ns/1ps
package icat_pkg;
  localparam int MAXI = 64;
  localparam int HALF = 32;
  localparam int IDW  = 6;
  localparam int RA_W = 3;

  localparam logic [RA_W-1:0] A_RX_LO = 3'd0;
  localparam logic [RA_W-1:0] A_ACK   = 3'd1;
  localparam logic [RA_W-1:0] A_TO_LO = 3'd2;
  localparam logic [RA_W-1:0] A_TO_HI = 3'd3;

  // number is usable: implemented and reachable in the current mode
  function automatic logic num_ok(input logic [IDW-1:0] n, input logic ext, input int ni);
    return (int'(n) < ni) && (ext || !n[IDW-1]);
  endfunction

  function automatic logic [MAXI-1:0] onehot(input logic [IDW-1:0] n, input logic en);
    return en ? (MAXI'(1) << n) : '0;
  endfunction
endpackage

// File: rtl/icat_w1c.sv
`timescale 1ns/1ps
module icat_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // set takes priority over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/icat_chan.sv
`timescale 1ns/1ps
module icat_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ack_in,
  input  logic [CNT_W-1:0] reload,
  output logic             pend,
  output logic             ack_hit,
  output logic             to_fire
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  assign ack_hit = ack_in & pend;
  assign to_fire = pend & ~ack_in & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (arm) begin
      pend <= 1'b1;
      cnt  <= reload;
    end else if (ack_hit || to_fire) begin
      pend <= 1'b0;
    end else if (pend) begin
      cnt  <= dec_sat(cnt);
    end
  end
endmodule

// File: rtl/icat_track.sv
`timescale 1ns/1ps
module icat_track import icat_pkg::*; #(
  parameter int NUM_INT = 64,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              rx_valid,
  input  logic              rx_is_ack,
  input  logic [IDW-1:0]    rx_num,
  input  logic              tx_valid,
  input  logic [IDW-1:0]    tx_num,
  input  logic [CNT_W-1:0]  tx_reload,
  input  logic [MAXI-1:0]   tick_mask,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [31:0]       rd_data
);
  localparam int NI  = NUM_INT;
  localparam int AKW = (NUM_INT < HALF) ? NUM_INT : HALF;

  // decoded events
  logic [MAXI-1:0] rx_dec, tx_dec;
  logic [NI-1:0]   int_ev, ack_ev, arm;
  logic [NI-1:0]   pend, ack_hit, to_fire;

  assign rx_dec = onehot(rx_num, rx_valid & num_ok(rx_num, ext_mode, NI));
  assign tx_dec = onehot(tx_num, tx_valid & num_ok(tx_num, ext_mode, NI));
  assign int_ev = rx_dec[NI-1:0] & {NI{~rx_is_ack}};
  assign ack_ev = rx_dec[NI-1:0] & {NI{rx_is_ack}};
  assign arm    = tx_dec[NI-1:0];

  for (genvar i = 0; i < NI; i++) begin : g_chan
    icat_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm[i]),
      .ack_in  (ack_ev[i]),
      .reload  (tx_reload),
      .pend    (pend[i]),
      .ack_hit (ack_hit[i]),
      .to_fire (to_fire[i])
    );
  end

  // set and clear vectors
  logic [NI-1:0]   rx_set, to_set, rx_q, to_q;
  logic [AKW-1:0]  ack_set, ack_q;
  logic [MAXI-1:0] rx_clr64, to_clr64;
  logic [31:0]     ack_clr32;

  assign rx_set  = int_ev & tick_mask[NI-1:0];
  assign to_set  = to_fire & tick_mask[NI-1:0];
  assign ack_set = ack_hit[AKW-1:0] & tick_mask[AKW-1:0] & {AKW{~ext_mode}};

  always_comb begin
    rx_clr64  = '0;
    to_clr64  = '0;
    ack_clr32 = '0;
    if (wr_en) begin
      case (wr_addr)
        A_RX_LO: rx_clr64[HALF-1:0] = wr_data;
        A_ACK: begin
          if (ext_mode) rx_clr64[MAXI-1:HALF] = wr_data;
          else          ack_clr32 = wr_data;
        end
        A_TO_LO: to_clr64[HALF-1:0] = wr_data;
        A_TO_HI: if (ext_mode) to_clr64[MAXI-1:HALF] = wr_data;
        default: ;
      endcase
    end
  end

  icat_w1c #(.W(NI)) u_rx_st (
    .clk(clk), .rst_n(rst_n), .set(rx_set), .clr(rx_clr64[NI-1:0]), .q(rx_q));
  icat_w1c #(.W(AKW)) u_ack_st (
    .clk(clk), .rst_n(rst_n), .set(ack_set), .clr(ack_clr32[AKW-1:0]), .q(ack_q));
  icat_w1c #(.W(NI)) u_to_st (
    .clk(clk), .rst_n(rst_n), .set(to_set), .clr(to_clr64[NI-1:0]), .q(to_q));

  // padded views for read mux and checker
  logic [MAXI-1:0] rx_pad, to_pad, pend_pad, ack_hit_pad, to_fire_pad, rx_set_pad;
  logic [31:0]     ack_pad;

  always_comb begin
    rx_pad      = '0; rx_pad[NI-1:0]      = rx_q;
    to_pad      = '0; to_pad[NI-1:0]      = to_q;
    pend_pad    = '0; pend_pad[NI-1:0]    = pend;
    ack_hit_pad = '0; ack_hit_pad[NI-1:0] = ack_hit;
    to_fire_pad = '0; to_fire_pad[NI-1:0] = to_fire;
    rx_set_pad  = '0; rx_set_pad[NI-1:0]  = rx_set;
    ack_pad     = '0; ack_pad[AKW-1:0]    = ack_q;
  end

  always_comb begin
    case (rd_addr)
      A_RX_LO: rd_data = rx_pad[HALF-1:0];
      A_ACK:   rd_data = ext_mode ? rx_pad[MAXI-1:HALF] : ack_pad;
      A_TO_LO: rd_data = to_pad[HALF-1:0];
      A_TO_HI: rd_data = ext_mode ? to_pad[MAXI-1:HALF] : 32'd0;
      default: rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/icat_chk.sv
`timescale 1ns/1ps
module icat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] mask,
  input logic [63:0] rx_q,
  input logic [63:0] rx_set,
  input logic [63:0] to_q,
  input logic [63:0] pend,
  input logic [63:0] ack_hit,
  input logic [63:0] to_fire,
  input logic [31:0] ack_q
);
  // R1: status is empty on the first edge after reset release
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> (rx_q == '0 && to_q == '0 && ack_q == '0));

  // R2: a received bit only rises where the mask allowed it
  a_r2_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_q & ~$past(rx_q) & ~$past(mask)) == '0));

  // R3: an acknowledge bit only rises for a number that was pending
  a_r3_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_q & ~$past(ack_q) & ~$past(pend[31:0])) == '0));

  // R4: pending only drops through an acknowledge or an expiry
  a_r4_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend & ~$past(ack_hit | to_fire)) == '0));

  // R5: a timeout bit only rises for a pending, unmasked number
  a_r5_to_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((to_q & ~$past(to_q) & ~$past(pend & mask)) == '0));

  // R8: a hardware set is never lost to a same-edge clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rx_set) & ~rx_q) == '0));
endmodule

bind icat_track icat_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mask    (tick_mask),
  .rx_q    (rx_pad),
  .rx_set  (rx_set_pad),
  .to_q    (to_pad),
  .pend    (pend_pad),
  .ack_hit (ack_hit_pad),
  .to_fire (to_fire_pad),
  .ack_q   (ack_pad)
);

// File: tb/tb_icat_track.sv
`timescale 1ns/1ps
module tb_icat_track;
  localparam int NI = 40;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ext = 0, rx_valid = 0, rx_is_ack = 0, tx_valid = 0, wr_en = 0;
  logic [5:0] rx_num = '0, tx_num = '0;
  logic [CW-1:0] tx_reload = '0;
  logic [63:0] mask = '1;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;

  icat_track #(.NUM_INT(NI), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext),
    .rx_valid(rx_valid), .rx_is_ack(rx_is_ack), .rx_num(rx_num),
    .tx_valid(tx_valid), .tx_num(tx_num), .tx_reload(tx_reload),
    .tick_mask(mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int errs = 0, checks = 0;

  // behavioural reference model
  bit m_rx[64], m_ack[32], m_to[64], m_pend[64];
  int m_cnt[64];
  bit n_rx[64], n_ack[32], n_to[64], n_pend[64];
  int n_cnt[64];
  bit e_ack, e_to, e_arm;

  function automatic bit okn(int n, bit e);
    return (n < NI) && (e || n < 32);
  endfunction

  function automatic logic [31:0] mread(int a);
    logic [31:0] v = '0;
    for (int j = 0; j < 32; j++) begin
      case (a)
        0: v[j] = m_rx[j];
        1: v[j] = ext ? m_rx[j+32] : m_ack[j];
        2: v[j] = m_to[j];
        3: v[j] = ext ? m_to[j+32] : 1'b0;
        default: v[j] = 1'b0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_rx[i] = 0; m_to[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
        if (i < 32) m_ack[i] = 0;
      end
    end else begin
      n_rx = m_rx; n_ack = m_ack; n_to = m_to; n_pend = m_pend; n_cnt = m_cnt;
      if (wr_en)
        for (int j = 0; j < 32; j++)
          if (wr_data[j])
            case (wr_addr)
              3'd0: n_rx[j] = 0;
              3'd1: if (ext) n_rx[j+32] = 0; else n_ack[j] = 0;
              3'd2: n_to[j] = 0;
              3'd3: if (ext) n_to[j+32] = 0;
              default: ;
            endcase
      for (int i = 0; i < 64; i++) begin
        e_ack = rx_valid && rx_is_ack && (int'(rx_num) == i) && okn(i, ext) && m_pend[i];
        e_to  = m_pend[i] && !e_ack && (m_cnt[i] == 0);
        e_arm = tx_valid && (int'(tx_num) == i) && okn(i, ext);
        if (rx_valid && !rx_is_ack && (int'(rx_num) == i) && okn(i, ext) && mask[i]) n_rx[i] = 1;
        if (e_ack && mask[i] && !ext && i < 32) n_ack[i] = 1;
        if (e_to && mask[i]) n_to[i] = 1;
        if (e_arm) begin n_pend[i] = 1; n_cnt[i] = int'(tx_reload); end
        else if (e_ack || e_to) n_pend[i] = 0;
        else if (m_pend[i] && m_cnt[i] != 0) n_cnt[i] = m_cnt[i] - 1;
      end
      m_rx = n_rx; m_ack = n_ack; m_to = n_to; m_pend = n_pend; m_cnt = n_cnt;
    end
  end

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h (rd_addr %0d, t=%0t)", r, got, exp, rd_addr, $time);
    end
  endtask

  function automatic string reqof(int a);
    case (a)
      0: return "R2";
      1: return ext ? "R7" : "R3";
      2: return "R5";
      3: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic cmp_all();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #0.1;
      chk(reqof(a), rd_data, mread(a));
    end
  endtask

  task automatic cyc();
    @(posedge clk); #0.5;
    cmp_all();
  endtask

  task automatic expb(int a, int b, bit v, string r);
    rd_addr = 3'(a); #0.1;
    chk(r, {31'd0, rd_data[b]}, {31'd0, v});
  endtask

  task automatic ev_rx(int n, bit ack);
    rx_valid = 1; rx_is_ack = ack; rx_num = 6'(n); cyc(); rx_valid = 0;
  endtask
  task automatic ev_tx(int n, int r);
    tx_valid = 1; tx_num = 6'(n); tx_reload = CW'(r); cyc(); tx_valid = 0;
  endtask
  task automatic ev_wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d; cyc(); wr_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); #0.1; chk("R1", rd_data, 32'd0); end
    @(negedge clk); rst_n = 1;
    cyc();
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); #0.1; chk("R1", rd_data, 32'd0); end

    // R2: received codes and mask gating
    ev_rx(3, 0); ev_rx(17, 0);
    expb(0, 3, 1, "R2"); expb(0, 17, 1, "R2");
    mask[5] = 0; ev_rx(5, 0); expb(0, 5, 0, "R2"); mask = '1;
    // R6: high number outside extended mode
    ev_rx(35, 0); expb(1, 3, 0, "R6");

    // R3: acknowledge after a send
    ev_tx(4, 3); cyc(); ev_rx(4, 1); expb(1, 4, 1, "R3");
    repeat (6) cyc(); expb(2, 4, 0, "R5");
    // R4: acknowledge with nothing pending
    ev_rx(9, 1); expb(1, 9, 0, "R4");

    // R5: timeout exactly R+1 cycles after the send edge
    ev_tx(6, 2); cyc(); cyc(); expb(2, 6, 0, "R5");
    cyc(); expb(2, 6, 1, "R5");
    ev_rx(6, 1); expb(1, 6, 0, "R4");
    // R5: acknowledge on the expiry edge wins
    ev_tx(10, 1); cyc(); ev_rx(10, 1);
    expb(1, 10, 1, "R5"); expb(2, 10, 0, "R5");
    // R5: masked timeout
    mask[11] = 0; ev_tx(11, 0); cyc(); expb(2, 11, 0, "R5"); mask = '1;

    // R9: re-send restarts the window
    ev_tx(7, 2); cyc(); ev_tx(7, 2); cyc(); cyc(); expb(2, 7, 0, "R9");
    cyc(); expb(2, 7, 1, "R9");

    // R8: write-to-clear and set-wins
    ev_wr(0, 32'h8); expb(0, 3, 0, "R8"); expb(0, 17, 1, "R8");
    rx_valid = 1; rx_is_ack = 0; rx_num = 6'd17;
    wr_en = 1; wr_addr = 3'd0; wr_data = 32'h1 << 17;
    cyc(); rx_valid = 0; wr_en = 0;
    expb(0, 17, 1, "R8");

    // R7: extended mode
    ext = 1;
    ev_rx(35, 0); expb(1, 3, 1, "R7");
    ev_rx(45, 0); expb(1, 13, 0, "R6");
    ev_tx(33, 1); cyc(); cyc(); expb(3, 1, 1, "R7");
    ev_wr(1, 32'h8); expb(1, 3, 0, "R7");
    rd_addr = 3'd5; #0.1; chk("R6", rd_data, 32'd0);
    ext = 0;
    rd_addr = 3'd3; #0.1; chk("R7", rd_data, 32'd0);

    // random phase, compared on every clock
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 250) ext = ~ext;
      if (k % 100 == 0) mask = {$urandom, $urandom} | {$urandom, $urandom};
      rx_valid  = ($urandom_range(0, 9) < 3);
      rx_is_ack = $urandom_range(0, 1);
      rx_num    = 6'($urandom_range(0, 47));
      tx_valid  = ($urandom_range(0, 9) < 2);
      tx_num    = 6'($urandom_range(0, 47));
      tx_reload = CW'($urandom_range(0, 12));
      wr_en     = ($urandom_range(0, 9) == 0);
      wr_addr   = 3'($urandom_range(0, 4));
      wr_data   = $urandom;
      cyc();
    end
    rx_valid = 0; tx_valid = 0; wr_en = 0;
    repeat (20) cyc();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule